// File: doc/BRIEF.md
# Transaction Conflict Detector with Bloom Signatures

This block sits beside a small group of processor threads that run software transactional memory. It detects conflicts after the fact. Each thread's runtime reports what it is doing as a stream of tagged commands: start of a transaction, each address read, each address it intends to write, a request to commit, and the end of the transaction. The block keeps three compact Bloom signatures per thread. The first holds the addresses the thread has read. The second holds the addresses the thread has staged for writing. The third holds the addresses that other threads have written in commits that were granted. From these signatures it decides whether a thread may commit, and it keeps a violation flag per thread that software can poll at low cost.

Commands arrive on a valid/ready stream, and a command is taken only in a cycle where both are high. The block accepts one command per cycle with no internal queue. It lowers `cmd_ready` only while in reset, so a producer never stalls after reset is released. Each commit is resolved in the cycle it is accepted, so commits are serialized in arrival order. A granted commit publishes the committer's write signature to every other active thread before the next command is looked at. The block answers each accepted commit with a one-cycle response pulse. False positives can cause spurious violations. False negatives cannot occur.

Top module: `tm_conflict_detector`

## Requirements
- R1: While reset is asserted and after it is released, `resp_valid` is 0 and every `viol_flags` bit is 0. From the first clock edge after release, `cmd_ready` is 1.
- R2: Each signature is made of two banks of FILTER_BITS/2 bits. The bank-A index XORs address bit i into index bit (i mod W). The bank-B index XORs address bit i into index bit ((i + i div W) mod W). Here W = log2(FILTER_BITS/2). An address is present in a signature when its bank-A bit and its bank-B bit are both set. Two addresses with equal index pairs cannot be told apart.
- R3: A recorded read is never lost. If thread T read address X in its current transaction, and another thread is later granted a commit that wrote X, then `viol_flags[T]` becomes 1 on the clock edge that accepts that commit.
- R4: A read by thread T of an address that is present in T's signature of other threads' committed writes sets `viol_flags[T]` on the edge that accepts the read.
- R5: A commit that is accepted and applies (see R8 and R9) produces `resp_valid`=1 for exactly the following cycle. `resp_tid` carries the thread, and `resp_grant`=1 exactly when `viol_flags` for that thread was 0 when the commit was accepted.
- R6: A denied commit publishes nothing. The flags of the other threads do not change.
- R7: Opcode BEGIN (0) for thread T clears all three of T's signatures and T's flag in one cycle, marks T active, and latches the command's epoch as T's transaction epoch.
- R8: A READ (1), WRITE (2), COMMIT (3) or END (4) command whose epoch differs from the thread's transaction epoch is ignored. Such a commit gives no response.
- R9: Commands for an inactive thread (never begun, or after END) are ignored. An inactive thread's flag is not raised by other threads' commits.
- R10: A thread's own staged writes never raise its own flag. Reading an address it has itself staged for writing still lets the commit be granted.
- R11: Commits are resolved in arrival order. A commit accepted after a granted commit that violated that thread is denied.
- R12: A command presented while `cmd_ready` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 3 | Opcode: 0 begin, 1 read, 2 write, 3 commit, 4 end |
| cmd_tid | input | TID_W | Thread the command belongs to |
| cmd_epoch | input | EPOCH_W | Epoch number carried by the command |
| cmd_addr | input | ADDR_W | Address for read and write commands |
| resp_valid | output | 1 | One-cycle commit response pulse |
| resp_tid | output | TID_W | Thread being answered |
| resp_grant | output | 1 | 1 = commit granted, 0 = denied |
| viol_flags | output | NUM_THREADS | Per-thread violation flag |

## Verification
The bench builds the block with four threads, 16-bit addresses, 8-bit epochs and a 64-bit signature. This gives two banks of 32 bits and 5-bit indices. With signatures that small, two different addresses easily share an index pair. The bench therefore hits deliberate aliasing, a false positive that a bit-accurate model must predict exactly, and it also hits naturally crowded signatures during the random run. Four threads leave enough room for a committer, a reader it violates, a bystander and an inactive thread to coexist in one scenario.

// File: rtl/tmcd_pkg.sv
package tmcd_pkg;
  typedef enum logic [2:0] {
    OP_BEGIN  = 3'd0,
    OP_READ   = 3'd1,
    OP_WRITE  = 3'd2,
    OP_COMMIT = 3'd3,
    OP_END    = 3'd4
  } op_e;
endpackage

// File: rtl/tmcd_hash.sv
module tmcd_hash #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 9
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_a_o,
  output logic [IDX_W-1:0]  idx_b_o
);
  // Two XOR folds with different bit placement, giving two unrelated indices.
  always_comb begin
    idx_a_o = '0;
    idx_b_o = '0;
    for (int i = 0; i < ADDR_W; i++) begin
      idx_a_o[i % IDX_W]               = idx_a_o[i % IDX_W] ^ addr_i[i];
      idx_b_o[(i + i / IDX_W) % IDX_W] = idx_b_o[(i + i / IDX_W) % IDX_W] ^ addr_i[i];
    end
  end
endmodule

// File: rtl/tmcd_thread.sv
module tmcd_thread #(
  parameter int BANK    = 512,
  parameter int IDX_W   = 9,
  parameter int EPOCH_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               begin_i,
  input  logic [EPOCH_W-1:0] epoch_i,
  input  logic               end_i,
  input  logic               rd_ins_i,
  input  logic               wr_ins_i,
  input  logic               pend_clr_i,
  input  logic [IDX_W-1:0]   idx_a_i,
  input  logic [IDX_W-1:0]   idx_b_i,
  input  logic               merge_en_i,
  input  logic [BANK-1:0]    merge_a_i,
  input  logic [BANK-1:0]    merge_b_i,
  output logic [BANK-1:0]    pend_a_o,
  output logic [BANK-1:0]    pend_b_o,
  output logic               viol_o,
  output logic               active_o,
  output logic [EPOCH_W-1:0] epoch_o
);
  logic [BANK-1:0] rd_a, rd_b, ext_a, ext_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_a <= '0; rd_b <= '0; ext_a <= '0; ext_b <= '0;
      pend_a_o <= '0; pend_b_o <= '0;
      viol_o <= 1'b0; active_o <= 1'b0; epoch_o <= '0;
    end else if (begin_i) begin
      rd_a <= '0; rd_b <= '0; ext_a <= '0; ext_b <= '0;
      pend_a_o <= '0; pend_b_o <= '0;
      viol_o <= 1'b0; active_o <= 1'b1; epoch_o <= epoch_i;
    end else begin
      if (rd_ins_i) begin
        rd_a[idx_a_i] <= 1'b1;
        rd_b[idx_b_i] <= 1'b1;
        if (ext_a[idx_a_i] && ext_b[idx_b_i]) viol_o <= 1'b1;
      end
      if (wr_ins_i) begin
        pend_a_o[idx_a_i] <= 1'b1;
        pend_b_o[idx_b_i] <= 1'b1;
      end
      if (pend_clr_i) begin
        pend_a_o <= '0;
        pend_b_o <= '0;
      end
      if (end_i) active_o <= 1'b0;
      if (merge_en_i && active_o) begin
        ext_a <= ext_a | merge_a_i;
        ext_b <= ext_b | merge_b_i;
        // Shared bits in both banks: some write may match a read. Never misses one.
        if ((|(rd_a & merge_a_i)) && (|(rd_b & merge_b_i))) viol_o <= 1'b1;
      end
    end
  end

  AST_BEGIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    begin_i |=> (!viol_o && active_o && rd_a == '0 && ext_a == '0 && pend_a_o == '0)); // R7
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_o && !begin_i) |=> viol_o); // R3
  AST_READ_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ins_i && !begin_i) |=> (rd_a[$past(idx_a_i)] && rd_b[$past(idx_b_i)])); // R3
  AST_MERGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (merge_en_i && active_o && !begin_i) |=>
      (((ext_a & $past(merge_a_i)) == $past(merge_a_i)) &&
       ((ext_b & $past(merge_b_i)) == $past(merge_b_i)))); // R4
  AST_IDLE_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_o && !begin_i && !viol_o) |=> !viol_o); // R9
endmodule

// File: rtl/tm_conflict_detector.sv
module tm_conflict_detector #(
  parameter int NUM_THREADS = 4,
  parameter int ADDR_W      = 32,
  parameter int EPOCH_W     = 8,
  parameter int FILTER_BITS = 256,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int BANK       = FILTER_BITS / 2,
  localparam int IDX_W      = $clog2(BANK)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic [2:0]             cmd_op,
  input  logic [TID_W-1:0]       cmd_tid,
  input  logic [EPOCH_W-1:0]     cmd_epoch,
  input  logic [ADDR_W-1:0]      cmd_addr,
  output logic                   resp_valid,
  output logic [TID_W-1:0]       resp_tid,
  output logic                   resp_grant,
  output logic [NUM_THREADS-1:0] viol_flags
);
  import tmcd_pkg::*;

  op_e              op;
  logic             fire, match, commit_ok, grant;
  logic [IDX_W-1:0] idx_a, idx_b;
  logic [BANK-1:0]  pend_a [NUM_THREADS];
  logic [BANK-1:0]  pend_b [NUM_THREADS];
  logic [EPOCH_W-1:0] ep [NUM_THREADS];
  logic [NUM_THREADS-1:0] act;
  logic [BANK-1:0]  sel_a, sel_b;

  assign op        = op_e'(cmd_op);
  assign fire      = cmd_valid && cmd_ready;
  assign match     = act[cmd_tid] && (ep[cmd_tid] == cmd_epoch);
  assign commit_ok = fire && op == OP_COMMIT && match;
  assign grant     = commit_ok && !viol_flags[cmd_tid];
  assign sel_a     = pend_a[cmd_tid];
  assign sel_b     = pend_b[cmd_tid];

  tmcd_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash (
    .addr_i(cmd_addr), .idx_a_o(idx_a), .idx_b_o(idx_b)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic mine;
    assign mine = fire && (cmd_tid == TID_W'(t));
    tmcd_thread #(.BANK(BANK), .IDX_W(IDX_W), .EPOCH_W(EPOCH_W)) u_thr (
      .clk(clk), .rst_n(rst_n),
      .begin_i(mine && op == OP_BEGIN),
      .epoch_i(cmd_epoch),
      .end_i(mine && match && op == OP_END),
      .rd_ins_i(mine && match && op == OP_READ),
      .wr_ins_i(mine && match && op == OP_WRITE),
      .pend_clr_i(mine && match && (op == OP_COMMIT || op == OP_END)),
      .idx_a_i(idx_a), .idx_b_i(idx_b),
      .merge_en_i(grant && (cmd_tid != TID_W'(t))),
      .merge_a_i(sel_a), .merge_b_i(sel_b),
      .pend_a_o(pend_a[t]), .pend_b_o(pend_b[t]),
      .viol_o(viol_flags[t]), .active_o(act[t]), .epoch_o(ep[t])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_ready  <= 1'b0;
      resp_valid <= 1'b0;
      resp_tid   <= '0;
      resp_grant <= 1'b0;
    end else begin
      cmd_ready  <= 1'b1;
      resp_valid <= commit_ok;
      resp_tid   <= cmd_tid;
      resp_grant <= grant;
    end
  end

  AST_GRANT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_grant) |-> !viol_flags[resp_tid]); // R5
  AST_IDLE_NO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |=> !resp_valid); // R12
  AST_RESP_ONLY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op != OP_COMMIT) |=> !resp_valid); // R5
endmodule

// File: tb/test_tm_conflict_detector.sv
module test_tm_conflict_detector;
  localparam int NT = 4, AW = 16, EW = 8, FB = 64;
  localparam int BK = FB / 2, IW = $clog2(BK);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [1:0] cmd_tid = '0;
  logic [EW-1:0] cmd_epoch = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic resp_valid, resp_grant;
  logic [1:0] resp_tid;
  logic [NT-1:0] viol_flags;

  int total = 0, bad = 0, cyc = 0;

  tm_conflict_detector #(.NUM_THREADS(NT), .ADDR_W(AW), .EPOCH_W(EW), .FILTER_BITS(FB))
    i_tm_conflict_detector (.*);

  always #2 clk = ~clk;

  // bench model
  bit [BK-1:0] m_rda [NT], m_rdb [NT], m_exa [NT], m_exb [NT], m_pa [NT], m_pb [NT];
  bit m_v [NT], m_act [NT];
  bit [EW-1:0] m_ep [NT];

  function automatic bit [IW-1:0] ha(bit [AW-1:0] a);
    bit [IW-1:0] h = '0;
    for (int i = 0; i < AW; i++) h[i % IW] ^= a[i];
    return h;
  endfunction
  function automatic bit [IW-1:0] hb(bit [AW-1:0] a);
    bit [IW-1:0] h = '0;
    for (int i = 0; i < AW; i++) h[(i + i / IW) % IW] ^= a[i];
    return h;
  endfunction

  task automatic chk(bit ok, string req, string what, int act_v, int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act_v, exp_v);
    end
  endtask

  task automatic chk_flags(string req);
    for (int t = 0; t < NT; t++)
      chk(viol_flags[t] == m_v[t], req, $sformatf("viol_flags[%0d]", t), viol_flags[t], m_v[t]);
  endtask

  task automatic send(int t, int op, bit [AW-1:0] a, bit [EW-1:0] e, string req);
    bit match, exp_rv, exp_g;
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_tid = 2'(t); cmd_epoch = e; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0;
    match = m_act[t] && m_ep[t] == e;
    exp_rv = 0; exp_g = 0;
    case (op)
      0: begin
        m_rda[t] = '0; m_rdb[t] = '0; m_exa[t] = '0; m_exb[t] = '0;
        m_pa[t] = '0; m_pb[t] = '0; m_v[t] = 0; m_act[t] = 1; m_ep[t] = e;
      end
      1: if (match) begin
        m_rda[t][ha(a)] = 1; m_rdb[t][hb(a)] = 1;
        if (m_exa[t][ha(a)] && m_exb[t][hb(a)]) m_v[t] = 1;
      end
      2: if (match) begin m_pa[t][ha(a)] = 1; m_pb[t][hb(a)] = 1; end
      3: if (match) begin
        exp_rv = 1; exp_g = !m_v[t];
        if (exp_g)
          for (int u = 0; u < NT; u++)
            if (u != t && m_act[u]) begin
              if (|(m_rda[u] & m_pa[t]) && |(m_rdb[u] & m_pb[t])) m_v[u] = 1;
              m_exa[u] |= m_pa[t]; m_exb[u] |= m_pb[t];
            end
        m_pa[t] = '0; m_pb[t] = '0;
      end
      4: if (match) begin m_act[t] = 0; m_pa[t] = '0; m_pb[t] = '0; end
      default: ;
    endcase
    chk(resp_valid == exp_rv, req, "resp_valid", resp_valid, exp_rv);
    if (exp_rv) begin
      chk(resp_grant == exp_g, req, "resp_grant", resp_grant, exp_g);
      chk(resp_tid == 2'(t), req, "resp_tid", resp_tid, t);
    end
    chk_flags(req);
  endtask

  initial begin
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    chk(0, "WDOG", "watchdog expired", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit [AW-1:0] x, y, pool [32];
    void'($urandom(32'h5EED_0042));
    for (int t = 0; t < NT; t++) begin m_v[t] = 0; m_act[t] = 0; m_ep[t] = '0; end
    // R12: a command offered during reset is dropped
    cmd_valid = 1'b1; cmd_op = 3'd0; cmd_tid = 2'd1; cmd_epoch = 8'd9;
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b0, "R12", "cmd_ready in reset", cmd_ready, 0);
    chk(resp_valid == 1'b0, "R1", "resp_valid in reset", resp_valid, 0);
    cmd_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1", "cmd_ready after reset", cmd_ready, 1);
    chk(resp_valid == 1'b0, "R1", "resp_valid after reset", resp_valid, 0);
    chk_flags("R1");
    send(1, 1, 16'h0010, 8'd9, "R12"); // thread 1 was never begun: read ignored
    send(1, 3, 16'h0000, 8'd9, "R9");  // no response for inactive commit

    // R4, R5: read of an already committed address
    send(0, 0, 0, 8'd1, "R7"); send(1, 0, 0, 8'd1, "R7");
    send(1, 2, 16'h1234, 8'd1, "R5"); send(1, 3, 0, 8'd1, "R5");
    send(0, 1, 16'h1234, 8'd1, "R4");
    chk(viol_flags[0] == 1'b1, "R4", "reader flagged", viol_flags[0], 1);
    send(0, 3, 0, 8'd1, "R5");
    // R3, R11: earlier read violated by later granted commit
    send(2, 0, 0, 8'd3, "R7"); send(2, 1, 16'h0BEE, 8'd3, "R3");
    send(3, 0, 0, 8'd4, "R7"); send(3, 2, 16'h0BEE, 8'd4, "R3"); send(3, 3, 0, 8'd4, "R3");
    chk(viol_flags[2] == 1'b1, "R3", "earlier reader flagged", viol_flags[2], 1);
    send(2, 3, 0, 8'd3, "R11");
    // R7: begin clears
    send(0, 0, 0, 8'd7, "R7");
    chk(viol_flags[0] == 1'b0, "R7", "flag cleared by begin", viol_flags[0], 0);
    // R8: stale epoch ignored
    send(1, 0, 0, 8'd5, "R7"); send(1, 2, 16'h0C0C, 8'd5, "R8"); send(1, 3, 0, 8'd5, "R8");
    send(0, 1, 16'h0C0C, 8'd6, "R8"); send(0, 3, 0, 8'd6, "R8");
    chk(viol_flags[0] == 1'b0, "R8", "stale read ignored", viol_flags[0], 0);
    // R9: ended thread is not violated
    send(2, 0, 0, 8'd8, "R7"); send(2, 1, 16'h0D0D, 8'd8, "R9"); send(2, 4, 0, 8'd8, "R9");
    send(1, 2, 16'h0D0D, 8'd5, "R9"); send(1, 3, 0, 8'd5, "R9");
    chk(viol_flags[2] == 1'b0, "R9", "inactive untouched", viol_flags[2], 0);
    // R6: denied commit publishes nothing
    send(0, 0, 0, 8'd2, "R7"); send(0, 1, 16'h0E0E, 8'd2, "R6");
    send(1, 0, 0, 8'd2, "R7"); send(1, 1, 16'h0F0F, 8'd2, "R6");
    send(3, 0, 0, 8'd2, "R7"); send(3, 2, 16'h0F0F, 8'd2, "R6"); send(3, 3, 0, 8'd2, "R6");
    send(1, 2, 16'h0E0E, 8'd2, "R6"); send(1, 3, 0, 8'd2, "R6");
    chk(viol_flags[0] == 1'b0, "R6", "no publish on deny", viol_flags[0], 0);
    // R10: own staged writes do not self-violate
    send(3, 0, 0, 8'd4, "R7"); send(3, 2, 16'h0A0A, 8'd4, "R10");
    send(3, 1, 16'h0A0A, 8'd4, "R10"); send(3, 3, 0, 8'd4, "R10");
    // R2: aliased address produces a predicted false positive
    x = 16'h3C5A; y = x;
    for (int k = 1; k < 65536; k++)
      if (ha(16'(k)) == ha(x) && hb(16'(k)) == hb(x) && 16'(k) != x) begin y = 16'(k); break; end
    send(0, 0, 0, 8'd1, "R7"); send(0, 1, x, 8'd1, "R2");
    send(1, 0, 0, 8'd1, "R7"); send(1, 2, y, 8'd1, "R2"); send(1, 3, 0, 8'd1, "R2");
    chk(viol_flags[0] == 1'b1 && y != x, "R2", "alias flags reader", viol_flags[0], 1);

    // random phase
    for (int k = 0; k < 32; k++) pool[k] = 16'($urandom);
    for (int n = 0; n < 4000; n++) begin
      int t, r, op;
      bit [EW-1:0] e;
      t = $urandom % NT; r = $urandom % 100;
      op = (r < 6) ? 0 : (r < 46) ? 1 : (r < 76) ? 2 : (r < 92) ? 3 : 4;
      e = (op == 0) ? 8'($urandom) : (($urandom % 20 == 0) ? m_ep[t] + 8'd1 : m_ep[t]);
      send(t, op, pool[$urandom % 32], e, "R3 R4 R5 R8 R11");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule